// File: doc/BRIEF.md
# Video-Memory Block-Transfer DMA

This engine copies data from anywhere in a 16-bit address space into an 8 KiB video-memory window, in aligned 16-byte chunks. A processor sets it up through five byte-wide registers: two bytes of source pointer, two bytes of destination pointer, and one control byte. Writing the control byte sets the chunk count and the pacing mode, and starts the transfer. Reading the control byte back gives the chunks still to go and an idle flag.

The engine has two pacing modes. In burst mode the whole transfer runs back to back, and `busy` is held so that the processor can be stalled. In line-paced mode the engine moves a single chunk on each rising edge of a horizontal-blank strobe and stays quiet in between. A line-paced transfer can be abandoned by writing the control byte with its top bit clear.

Memory is reached through one byte-wide master port with a synchronous read. A read address presented in one cycle returns its data in the next cycle. Each byte therefore takes a read cycle followed by a write cycle.

Top module: `vram_blit_dma`

## Requirements
- R1: After reset the engine is idle: `busy` and `mem_we` are 0, `mem_addr` is 0, and a read of the control register (select 4) returns 0xFF.
- R2: The source pointer is {select 0 byte, select 1 byte with its low 4 bits forced to 0}. The first read of a transfer uses that address, and reads then step up by one per byte.
- R3: The write address is 0x8000 OR the low 13 bits of {select 2 byte, select 3 byte with its low 4 bits forced to 0}. It steps up by one per byte and wraps from 0x9FFF to 0x8000.
- R4: A control write (select 4) loads a chunk count of value[6:0]+1, and exactly 16 bytes are written per chunk.
- R5: In burst mode (value bit 7 = 0), from the cycle after the control write, the engine alternates a read cycle (`mem_addr` = source, `mem_we` = 0) with a write cycle (`mem_addr` = destination, `mem_we` = 1, `mem_wdata` = `mem_rdata`), with no gap. `busy` is high for exactly 2 cycles per byte.
- R6: In line-paced mode (value bit 7 = 1) nothing moves after the control write. Each rising edge of `hblank` moves exactly one chunk, `busy` is high only while that chunk moves, and the transfer ends after the last chunk.
- R7: A control-register read returns {~active, (remaining chunks − 1)[6:0]}. This is 0xFF whenever the engine is idle. Selects 0–3 and 5–7 read 0xFF.
- R8: A control write with bit 7 = 0 while a line-paced transfer is active cancels it in the next cycle, including in the middle of a chunk. `busy` drops, the readback becomes 0xFF, no new transfer starts, and later `hblank` edges move nothing.
- R9: Writes to selects 0–3 during a transfer do not change that transfer's addresses.
- R10: In line-paced mode, each chunk continues from the addresses where the previous chunk stopped.
- R11: Holding `hblank` high moves only one chunk. A rising edge that arrives while a chunk is moving is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 src high, 1 src low, 2 dst high, 3 dst low, 4 control |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data for the selected register (combinational) |
| hblank | input | 1 | Horizontal-blank strobe; a rising edge paces line-paced mode |
| mem_addr | output | 16 | Memory address (0 when not moving) |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| busy | output | 1 | High while bytes are moving; stalls the processor |

## Verification
A bad byte index or phase bit would show up within two cycles, as a read and a write out of step on `mem_addr`/`mem_we` or a chunk of the wrong length. A bad remaining-chunk count would change the control readback in the very cycle after it went wrong. A stale pointer would place the next read or write at a wrong address on its next memory cycle. Because every output is compared each clock against an independent model, each of these faults is reported within one or two cycles of the cause.

// File: rtl/vbd_pkg.sv
package vbd_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int WIN_W    = 13;
    localparam int CHUNK_LG = 4;
    localparam int LEN_W    = 7;
    localparam int CNT_W    = LEN_W + 1;
    localparam int SEL_W    = 3;
    localparam logic [ADDR_W-1:0] WIN_BASE = 16'h8000;
    localparam logic [DATA_W-1:0] LO_MASK  = ~DATA_W'((1 << CHUNK_LG) - 1);

    typedef enum logic [SEL_W-1:0] {
        SEL_SRC_HI = 3'd0,
        SEL_SRC_LO = 3'd1,
        SEL_DST_HI = 3'd2,
        SEL_DST_LO = 3'd3,
        SEL_CTRL   = 3'd4
    } cfg_sel_e;

    typedef enum logic {
        MODE_BURST = 1'b0,
        MODE_LINE  = 1'b1
    } xfer_mode_e;

    typedef enum logic {
        PH_RD = 1'b0,
        PH_WR = 1'b1
    } phase_e;

    typedef struct packed {
        xfer_mode_e        mode;
        logic [CNT_W-1:0]  chunks;
        logic [ADDR_W-1:0] src;
        logic [WIN_W-1:0]  dst_off;
    } xfer_cmd_t;

    function automatic logic [DATA_W-1:0] status_byte(input logic act,
                                                      input logic [CNT_W-1:0] chunks);
        logic [DATA_W-1:0] rem;
        rem = DATA_W'(chunks) - DATA_W'(1);
        return {~act, rem[DATA_W-2:0]};
    endfunction

    function automatic logic [ADDR_W-1:0] window_addr(input logic [WIN_W-1:0] off);
        return {WIN_BASE[ADDR_W-1:WIN_W], off};
    endfunction

endpackage

// File: rtl/vbd_regfile.sv
module vbd_regfile
    import vbd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [SEL_W-1:0]      sel,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  eng_active,
    input  xfer_mode_e            eng_mode,
    input  logic [CNT_W-1:0]      eng_chunks,
    output logic [DATA_W-1:0]     rdata,
    output logic                  start,
    output logic                  cancel,
    output xfer_cmd_t             cmd
);

    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic              ctrl_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (wr) begin
            case (cfg_sel_e'(sel))
                SEL_SRC_HI: src_q[ADDR_W-1:DATA_W] <= wdata;
                SEL_SRC_LO: src_q[DATA_W-1:0]      <= wdata & LO_MASK;
                SEL_DST_HI: dst_q[ADDR_W-1:DATA_W] <= wdata;
                SEL_DST_LO: dst_q[DATA_W-1:0]      <= wdata & LO_MASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        ctrl_hit     = wr && (sel == SEL_CTRL);
        cancel       = ctrl_hit && eng_active && (eng_mode == MODE_LINE) && !wdata[DATA_W-1];
        start        = ctrl_hit && !cancel;
        cmd.mode     = xfer_mode_e'(wdata[DATA_W-1]);
        cmd.chunks   = {1'b0, wdata[LEN_W-1:0]} + CNT_W'(1);
        cmd.src      = src_q;
        cmd.dst_off  = dst_q[WIN_W-1:0];
        rdata        = (sel == SEL_CTRL) ? status_byte(eng_active, eng_chunks) : '1;
    end

    // R7: an idle engine always reads back as all ones
    assert_idle_readback_R7: assert property (@(posedge clk) disable iff (rst)
        (!eng_active && sel == SEL_CTRL) |-> rdata == 8'hFF);

    // R2: low nibble of the source is always zero
    assert_src_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        src_q[CHUNK_LG-1:0] == '0);

endmodule

// File: rtl/vbd_mover.sv
module vbd_mover
    import vbd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               cancel,
    input  xfer_cmd_t          cmd,
    input  logic               hblank,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               active,
    output xfer_mode_e         mode,
    output logic [CNT_W-1:0]   chunks,
    output logic               busy,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_we
);

    logic                active_q;
    xfer_mode_e          mode_q;
    logic [CNT_W-1:0]    chunks_q;
    logic                run_q;
    phase_e              phase_q;
    logic [CHUNK_LG-1:0] idx_q;
    logic [ADDR_W-1:0]   cur_src;
    logic [WIN_W-1:0]    cur_dst;
    logic                hb_q;
    logic                hb_rise;

    assign hb_rise = hblank && !hb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            mode_q   <= MODE_BURST;
            chunks_q <= '0;
            run_q    <= 1'b0;
            phase_q  <= PH_RD;
            idx_q    <= '0;
            cur_src  <= '0;
            cur_dst  <= '0;
            hb_q     <= 1'b0;
        end else begin
            hb_q <= hblank;
            if (cancel) begin
                active_q <= 1'b0;
                chunks_q <= '0;
                run_q    <= 1'b0;
                phase_q  <= PH_RD;
                idx_q    <= '0;
            end else if (start) begin
                active_q <= 1'b1;
                mode_q   <= cmd.mode;
                chunks_q <= cmd.chunks;
                run_q    <= (cmd.mode == MODE_BURST);
                phase_q  <= PH_RD;
                idx_q    <= '0;
                cur_src  <= cmd.src;
                cur_dst  <= cmd.dst_off;
            end else if (run_q) begin
                if (phase_q == PH_RD) begin
                    phase_q <= PH_WR;
                end else begin
                    phase_q <= PH_RD;
                    cur_src <= cur_src + ADDR_W'(1);
                    cur_dst <= cur_dst + WIN_W'(1);
                    idx_q   <= idx_q + CHUNK_LG'(1);
                    if (&idx_q) begin
                        chunks_q <= chunks_q - CNT_W'(1);
                        if (chunks_q == CNT_W'(1)) begin
                            active_q <= 1'b0;
                            run_q    <= 1'b0;
                        end else if (mode_q == MODE_LINE) begin
                            run_q <= 1'b0;
                        end
                    end
                end
            end else if (active_q && mode_q == MODE_LINE && hb_rise) begin
                run_q   <= 1'b1;
                phase_q <= PH_RD;
            end
        end
    end

    always_comb begin
        active    = active_q;
        mode      = mode_q;
        chunks    = chunks_q;
        busy      = run_q;
        mem_we    = run_q && (phase_q == PH_WR);
        mem_wdata = mem_we ? mem_rdata : '0;
        if (!run_q)
            mem_addr = '0;
        else if (phase_q == PH_WR)
            mem_addr = window_addr(cur_dst);
        else
            mem_addr = cur_src;
    end

    // R5: bytes only move while a transfer is live
    assert_busy_needs_active_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> active_q);

    // R3: every write lands inside the video window
    assert_write_in_window_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr[ADDR_W-1:WIN_W] == WIN_BASE[ADDR_W-1:WIN_W]);

    // R8: a cancel leaves the engine idle on the next cycle
    assert_cancel_stops_R8: assert property (@(posedge clk) disable iff (rst)
        cancel |=> (!active_q && !busy));

    // R4: a start loads the requested chunk count
    assert_start_loads_R4: assert property (@(posedge clk) disable iff (rst)
        start |=> (active_q && chunks_q == $past(cmd.chunks)));

    // R4: remaining chunks never exceed the largest request
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        chunks_q <= CNT_W'(1 << LEN_W));

    // R6: a waiting line-paced transfer stays quiet without a strobe edge
    assert_line_waits_R6: assert property (@(posedge clk) disable iff (rst)
        (active_q && mode_q == MODE_LINE && !run_q && !hb_rise && !start) |=> !busy);

endmodule

// File: rtl/vram_blit_dma.sv
module vram_blit_dma
    import vbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              hblank,
    output logic [15:0]       mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              busy
);

    logic             start;
    logic             cancel;
    xfer_cmd_t        cmd;
    logic             eng_active;
    xfer_mode_e       eng_mode;
    logic [CNT_W-1:0] eng_chunks;

    vbd_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (cfg_wr),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .eng_active (eng_active),
        .eng_mode   (eng_mode),
        .eng_chunks (eng_chunks),
        .rdata      (cfg_rdata),
        .start      (start),
        .cancel     (cancel),
        .cmd        (cmd)
    );

    vbd_mover u_mover (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cancel    (cancel),
        .cmd       (cmd),
        .hblank    (hblank),
        .mem_rdata (mem_rdata),
        .active    (eng_active),
        .mode      (eng_mode),
        .chunks    (eng_chunks),
        .busy      (busy),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

endmodule

// File: tb/vram_blit_dma_tb_top.sv
module vram_blit_dma_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = 3'd4;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        hblank = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    string cur_req = "R1";

    int wr_count = 0;
    logic [15:0] wr_log[$];
    logic [15:0] rd_log[$];

    // reference model state
    int m_active, m_line, m_chunks, m_run, m_phase, m_idx;
    int m_src, m_dst, m_srcreg, m_dstreg, m_hbq;

    always #5 clk = ~clk;

    vram_blit_dma dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hblank(hblank),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .busy(busy)
    );

    function automatic logic [7:0] pattern(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // synchronous-read memory stand-in
    always @(posedge clk) mem_rdata <= pattern(mem_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_active = 0; m_line = 0; m_chunks = 0; m_run = 0; m_phase = 0; m_idx = 0;
        m_src = 0; m_dst = 0; m_srcreg = 0; m_dstreg = 0; m_hbq = 0;
    endtask

    task automatic model_step();
        int edge_seen;
        int d;
        edge_seen = hblank && !m_hbq;
        m_hbq = hblank;
        d = cfg_wdata;
        if (cfg_wr && cfg_sel == 3'd0) m_srcreg = (m_srcreg & 'h00FF) | (d << 8);
        if (cfg_wr && cfg_sel == 3'd1) m_srcreg = (m_srcreg & 'hFF00) | (d & 'hF0);
        if (cfg_wr && cfg_sel == 3'd2) m_dstreg = (m_dstreg & 'h00FF) | (d << 8);
        if (cfg_wr && cfg_sel == 3'd3) m_dstreg = (m_dstreg & 'hFF00) | (d & 'hF0);
        if (cfg_wr && cfg_sel == 3'd4) begin
            if (m_active && m_line && (d & 'h80) == 0) begin
                m_active = 0; m_chunks = 0; m_run = 0; m_phase = 0; m_idx = 0;
            end else begin
                m_active = 1; m_line = (d >> 7) & 1; m_chunks = (d & 'h7F) + 1;
                m_run = !m_line; m_phase = 0; m_idx = 0;
                m_src = m_srcreg; m_dst = m_dstreg & 'h1FFF;
            end
        end else if (m_run) begin
            if (m_phase == 0) m_phase = 1;
            else begin
                m_phase = 0;
                m_src = (m_src + 1) & 'hFFFF;
                m_dst = (m_dst + 1) & 'h1FFF;
                m_idx++;
                if (m_idx == 16) begin
                    m_idx = 0;
                    m_chunks--;
                    if (m_chunks == 0) begin m_active = 0; m_run = 0; end
                    else if (m_line) m_run = 0;
                end
            end
        end else if (m_active && m_line && edge_seen) begin
            m_run = 1; m_phase = 0;
        end
    endtask

    always @(posedge clk) begin
        int e_we, e_addr, e_wd, e_rd;
        if (rst) model_reset();
        else model_step();
        #2;
        if (!rst && !done) begin
            e_we   = m_run && m_phase;
            e_addr = !m_run ? 0 : (m_phase ? ('h8000 | m_dst) : m_src);
            e_wd   = e_we ? pattern(16'(m_src)) : 0;
            e_rd   = (cfg_sel == 3'd4) ? (m_active ? ((m_chunks - 1) & 'h7F) : 'hFF) : 'hFF;
            chk(busy == 1'(m_run), cur_req, "busy", busy, m_run);
            chk(mem_we == 1'(e_we), cur_req, "mem_we", mem_we, e_we);
            chk(mem_addr == 16'(e_addr), cur_req, "mem_addr", mem_addr, e_addr);
            chk(mem_wdata == 8'(e_wd), cur_req, "mem_wdata", mem_wdata, e_wd);
            chk(cfg_rdata == 8'(e_rd), "R7", "cfg_rdata", cfg_rdata, e_rd);
            if (mem_we) begin wr_count++; wr_log.push_back(mem_addr); end
            else if (busy) rd_log.push_back(mem_addr);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic cfg(input logic [2:0] s, input logic [7:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0; cfg_sel = 3'd4;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic pulse_hb(input int len);
        @(negedge clk); hblank = 1'b1;
        repeat (len) @(negedge clk);
        hblank = 1'b0;
    endtask

    task automatic clear_logs();
        wr_count = 0; wr_log.delete(); rd_log.delete();
    endtask

    task automatic set_ptrs(input logic [15:0] s, input logic [15:0] d);
        cfg(3'd0, s[15:8]); cfg(3'd1, s[7:0]); cfg(3'd2, d[15:8]); cfg(3'd3, d[7:0]);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && mem_we == 0 && mem_addr == 0, "R1", "idle outputs", {busy, mem_we}, 0);
        chk(cfg_rdata == 8'hFF, "R1", "reset readback", cfg_rdata, 'hFF);
        cfg_sel = 3'd5; #1;
        chk(cfg_rdata == 8'hFF, "R7", "unused select", cfg_rdata, 'hFF);
        cfg_sel = 3'd4;

        // burst, unaligned pointers, pointer writes during the run
        cur_req = "R5";
        set_ptrs(16'h1237, 16'hC45F);
        clear_logs();
        cfg(3'd4, 8'h01);
        chk(cfg_rdata == 8'h01, "R7", "readback after start", cfg_rdata, 'h01);
        cfg(3'd0, 8'h77);
        cfg(3'd2, 8'h00);
        wait_idle();
        chk(rd_log[0] == 16'h1230, "R2", "first read address", rd_log[0], 'h1230);
        chk(wr_log[0] == 16'h8450, "R3", "first write address", wr_log[0], 'h8450);
        chk(wr_count == 32, "R4", "bytes for 2 chunks", wr_count, 32);
        chk(rd_log.size() == 32, "R5", "read cycles", rd_log.size(), 32);
        chk(rd_log[31] == 16'h124F, "R9", "last read address", rd_log[31], 'h124F);
        chk(wr_log[31] == 16'h846F, "R9", "last write address", wr_log[31], 'h846F);
        chk(cfg_rdata == 8'hFF, "R7", "readback when done", cfg_rdata, 'hFF);

        // window wrap
        cur_req = "R3";
        set_ptrs(16'h0100, 16'h3FF0);
        clear_logs();
        cfg(3'd4, 8'h01);
        wait_idle();
        chk(wr_log[15] == 16'h9FFF, "R3", "window top", wr_log[15], 'h9FFF);
        chk(wr_log[16] == 16'h8000, "R3", "window wrap", wr_log[16], 'h8000);

        // largest request
        cur_req = "R4";
        set_ptrs(16'h2000, 16'h8000);
        clear_logs();
        cfg(3'd4, 8'h7F);
        chk(cfg_rdata == 8'h7F, "R4", "max readback", cfg_rdata, 'h7F);
        wait_idle();
        chk(wr_count == 2048, "R4", "bytes for 128 chunks", wr_count, 2048);

        // line-paced transfer
        cur_req = "R6";
        set_ptrs(16'h4000, 16'h8800);
        clear_logs();
        cfg(3'd4, 8'h82);
        chk(cfg_rdata == 8'h02, "R7", "line readback", cfg_rdata, 'h02);
        repeat (10) @(negedge clk);
        chk(wr_count == 0 && busy == 0, "R6", "quiet before strobe", wr_count, 0);
        pulse_hb(1);
        wait_idle();
        chk(wr_count == 16, "R6", "one chunk per edge", wr_count, 16);
        chk(cfg_rdata == 8'h01, "R7", "readback after chunk", cfg_rdata, 'h01);
        @(negedge clk); hblank = 1'b1;
        repeat (60) @(negedge clk);
        hblank = 1'b0;
        chk(wr_count == 32, "R11", "held strobe moves one chunk", wr_count, 32);
        chk(wr_log[16] == 16'h8810, "R10", "chunk 2 write start", wr_log[16], 'h8810);
        chk(rd_log[16] == 16'h4010, "R10", "chunk 2 read start", rd_log[16], 'h4010);
        repeat (3) @(negedge clk);
        pulse_hb(1);
        @(negedge clk); @(negedge clk);
        hblank = 1'b1;
        @(negedge clk); hblank = 1'b0;
        wait_idle();
        chk(wr_count == 48, "R11", "edge during chunk ignored", wr_count, 48);
        chk(cfg_rdata == 8'hFF, "R6", "done after last chunk", cfg_rdata, 'hFF);
        pulse_hb(1);
        repeat (40) @(negedge clk);
        chk(wr_count == 48, "R6", "no move after end", wr_count, 48);

        // cancel between chunks
        cur_req = "R8";
        set_ptrs(16'h5000, 16'h9000);
        clear_logs();
        cfg(3'd4, 8'h83);
        pulse_hb(1);
        wait_idle();
        cfg(3'd4, 8'h00);
        chk(cfg_rdata == 8'hFF && busy == 0, "R8", "cancel between chunks", cfg_rdata, 'hFF);
        pulse_hb(1);
        repeat (40) @(negedge clk);
        chk(wr_count == 16, "R8", "no move after cancel", wr_count, 16);

        // cancel mid chunk
        clear_logs();
        cfg(3'd4, 8'h81);
        pulse_hb(1);
        repeat (4) @(negedge clk);
        cfg(3'd4, 8'h05);
        chk(busy == 0 && cfg_rdata == 8'hFF, "R8", "cancel mid chunk", cfg_rdata, 'hFF);
        n = wr_count;
        chk(n < 16, "R8", "chunk cut short", n, 15);
        pulse_hb(1);
        repeat (40) @(negedge clk);
        chk(wr_count == n, "R8", "no restart after cancel", wr_count, n);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule